// File: doc/BRIEF.md
# MSI Directory Parent Controller

This block is the parent side of an MSI coherence protocol serving a parameterised number of private, direct-mapped data caches. Children send it upgrade requests (a line address and the state they want) and downgrade responses (the state they have dropped to, optionally with a dirty line). The block answers with upgrade responses and, when another child holds a conflicting copy, with downgrade requests. Main memory is reached through a request/response port whose read data returns at least one cycle after the request is accepted.

The directory does not track every memory line. For each core and each cache row it keeps one state and one tag. A lookup of a line at a core compares the stored tag with the line's tag. A mismatch means the core cannot hold the line, so the state is taken as I. Incoming traffic arrives as two queue heads: one for downgrade responses and one for upgrade requests. Responses are always served first, so a stalled request can never block the responses that would release it.

Line addresses are `ADDR_W` bits wide. The low `log2(ROWS)` bits select the row and the remaining upper bits form the tag.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset every directory entry reads I. `out_valid` and `mem_req_valid` stay low until a message is presented.
- R2: A core whose stored tag at a line's row differs from that line's tag counts as I for the line and never receives a downgrade request for it.
- R3: A request for M (`2'b10`) is granted only when every other core is I (`2'b00`) for the line. Each other core found in S or M first receives a downgrade request (`out_is_resp`=0) to I.
- R4: A request for S (`2'b01`) is granted only when no other core is in M. A core holding M receives a downgrade request to S. Cores in S receive nothing.
- R5: While a request is stalled, each conflicting core receives exactly one downgrade request, issued in ascending core index. No duplicate is sent while its answer is outstanding.
- R6: A downgrade response that carries data (`in_resp_has_data`=1) writes that line to memory (`mem_req_we`=1) before any upgrade response that depends on it. That upgrade response carries the written value.
- R7: An upgrade response (`out_is_resp`=1) has `out_has_data`=1, with the line read from memory, only when the requester's directory state is I. Otherwise `out_has_data`=0 and `out_data`=0. A downgrade request never carries data.
- R8: A downgrade response head is consumed (`in_resp_deq`=1) whenever the controller is not mid-transaction, including while an upgrade request head is stalled. It takes priority over the request head.
- R9: The directory entry (state and tag) of a row is rewritten when an upgrade is granted and when a downgrade response for the row's stored line arrives. Later conflict decisions follow the new entry.
- R10: `out_valid` and `mem_req_valid` hold their message stable until accepted by `out_ready` or `mem_req_ready`. A memory read for an upgrade addresses the requested line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_resp_valid | input | 1 | Downgrade response head present |
| in_resp_child | input | CID_W | Core that sent the response |
| in_resp_addr | input | ADDR_W | Line address of the response |
| in_resp_state | input | 2 | State the core dropped to |
| in_resp_has_data | input | 1 | Response carries a dirty line |
| in_resp_data | input | LINE_W | Dirty line |
| in_resp_deq | output | 1 | Response head consumed this cycle |
| in_req_valid | input | 1 | Upgrade request head present |
| in_req_child | input | CID_W | Requesting core |
| in_req_addr | input | ADDR_W | Requested line address |
| in_req_state | input | 2 | Desired state (S or M) |
| in_req_deq | output | 1 | Request head consumed this cycle |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Outgoing queue accepts |
| out_is_resp | output | 1 | 1 upgrade response, 0 downgrade request |
| out_child | output | CID_W | Target core |
| out_addr | output | ADDR_W | Line address |
| out_state | output | 2 | Granted state or downgrade target |
| out_has_data | output | 1 | Message carries line data |
| out_data | output | LINE_W | Line data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory line address |
| mem_req_wdata | output | LINE_W | Write data |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | LINE_W | Read data |

## Verification
A response head is consumed in the same cycle it is presented when the controller is idle. If the controller is finishing a memory write, the response is consumed the cycle after that write is accepted. A downgrade request or a data-less upgrade response becomes valid one cycle after the request head is evaluated. Consecutive downgrade requests to different cores are at least two cycles apart. An upgrade response with data becomes valid one cycle after memory read data returns, and the read is issued only after every earlier write has been accepted. Because the bench throttles `out_ready` and `mem_req_ready`, it does not sample at fixed offsets. It records every handshake at the falling edge, when the signals that take effect at the next rising edge are settled, and compares each message in order against a behavioural directory model. Each wait is bounded in cycles, and after the last downgrade of a stall the bench waits eight idle cycles to confirm that no duplicate appears.

// File: rtl/msi_pkg.sv
// Shared types for the MSI directory controller.
// Assumes the state encoding I=0, S=1, M=2 so that numeric order matches M > S > I.
package msi_pkg;
    typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10} msi_t;
    typedef enum logic [2:0] {C_IDLE, C_WB, C_RD, C_RDW, C_SEND} ctl_t;
endpackage

// File: rtl/msi_dir_store.sv
// Compact directory: one state and one tag per core per cache row.
// The read port returns, for every core, the state of rd_addr (I on tag mismatch).
// The single write port can be told to write only when the stored tag matches.
module msi_dir_store
    import msi_pkg::*;
#(
    parameter int N_CORES = 2,
    parameter int ROWS    = 16,
    parameter int ADDR_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [N_CORES-1:0][1:0]      rd_state,
    input  logic                         wr_en,
    input  logic [$clog2(N_CORES > 1 ? N_CORES : 2)-1:0] wr_core,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  msi_t                         wr_state,
    input  logic                         wr_need_hit
);
    localparam int IDX_W = $clog2(ROWS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int CID_W = $clog2(N_CORES > 1 ? N_CORES : 2);

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_addr[IDX_W-1:0];
    assign rd_tag = rd_addr[ADDR_W-1:IDX_W];
    assign wr_idx = wr_addr[IDX_W-1:0];
    assign wr_tag = wr_addr[ADDR_W-1:IDX_W];

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        msi_t             st_q  [ROWS];
        logic [TAG_W-1:0] tag_q [ROWS];
        logic             sel;

        assign sel = wr_en && (wr_core == CID_W'(c)) &&
                     (!wr_need_hit || (tag_q[wr_idx] == wr_tag));

        // Per-core row storage: cleared to I on reset, rewritten on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    st_q[r]  <= ST_I;
                    tag_q[r] <= '0;
                end
            end else if (sel) begin
                st_q[wr_idx]  <= wr_state;
                tag_q[wr_idx] <= wr_tag;
            end
        end

        // Derived state: I unless the stored tag names the looked-up line.
        assign rd_state[c] = (tag_q[rd_idx] == rd_tag) ? st_q[rd_idx] : ST_I;
    end
endmodule

// File: rtl/msi_conflict.sv
// Permission check for one upgrade request against all other cores' states.
// Marks each core that blocks the grant and picks the lowest-index blocker
// that has not already been sent a downgrade request.
module msi_conflict
    import msi_pkg::*;
#(
    parameter int N_CORES = 2
) (
    input  logic [N_CORES-1:0][1:0] eff,
    input  logic [$clog2(N_CORES > 1 ? N_CORES : 2)-1:0] req_child,
    input  msi_t                    want,
    input  logic [N_CORES-1:0]      pend,
    output logic                    any_conflict,
    output logic                    issue_any,
    output logic [$clog2(N_CORES > 1 ? N_CORES : 2)-1:0] issue_idx,
    output msi_t                    target
);
    localparam int CID_W = $clog2(N_CORES > 1 ? N_CORES : 2);

    logic [N_CORES-1:0] blk;
    logic [N_CORES-1:0] fresh;

    for (genvar j = 0; j < N_CORES; j++) begin : g_chk
        // A core blocks M unless it is I, and blocks S only while it holds M.
        assign blk[j] = (req_child != CID_W'(j)) &&
                        ((want == ST_M) ? (eff[j] != ST_I) : (eff[j] == ST_M));
    end

    assign fresh        = blk & ~pend;
    assign any_conflict = |blk;
    assign target       = (want == ST_M) ? ST_I : ST_S;

    // Lowest-index blocker that still needs its downgrade request.
    always_comb begin
        issue_any = 1'b0;
        issue_idx = '0;
        for (int j = N_CORES - 1; j >= 0; j--) begin
            if (fresh[j]) begin
                issue_any = 1'b1;
                issue_idx = CID_W'(j);
            end
        end
    end
endmodule

// File: rtl/msi_dir_ctrl.sv
// Parent controller of the MSI protocol. Serves downgrade responses before
// upgrade requests, sends downgrade requests to conflicting cores, writes dirty
// data back and reads line data from memory for requesters holding I.
// Assumes memory answers reads in order, at least one cycle after acceptance,
// and that requests and responses stay at their queue heads until dequeued.
module msi_dir_ctrl
    import msi_pkg::*;
#(
    parameter int N_CORES = 2,
    parameter int ROWS    = 16,
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 32,
    localparam int CID_W  = $clog2(N_CORES > 1 ? N_CORES : 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_resp_valid,
    input  logic [CID_W-1:0]  in_resp_child,
    input  logic [ADDR_W-1:0] in_resp_addr,
    input  logic [1:0]        in_resp_state,
    input  logic              in_resp_has_data,
    input  logic [LINE_W-1:0] in_resp_data,
    output logic              in_resp_deq,
    input  logic              in_req_valid,
    input  logic [CID_W-1:0]  in_req_child,
    input  logic [ADDR_W-1:0] in_req_addr,
    input  logic [1:0]        in_req_state,
    output logic              in_req_deq,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_is_resp,
    output logic [CID_W-1:0]  out_child,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_state,
    output logic              out_has_data,
    output logic [LINE_W-1:0] out_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_data
);
    ctl_t                      st_q;
    logic [N_CORES-1:0]        pend_q;
    logic [CID_W-1:0]          cur_child;
    logic [ADDR_W-1:0]         cur_addr;
    msi_t                      cur_state;

    logic [ADDR_W-1:0]         rd_addr;
    logic [N_CORES-1:0][1:0]   dir_eff;
    logic                      wr_en, wr_need_hit;
    logic [CID_W-1:0]          wr_core;
    logic [ADDR_W-1:0]         wr_addr;
    msi_t                      wr_state;

    logic                      any_conflict, issue_any;
    logic [CID_W-1:0]          issue_idx;
    msi_t                      dg_target;
    logic                      grant_fire, dg_fire;

    msi_dir_store #(.N_CORES(N_CORES), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_state(dir_eff),
        .wr_en(wr_en), .wr_core(wr_core), .wr_addr(wr_addr),
        .wr_state(wr_state), .wr_need_hit(wr_need_hit)
    );

    msi_conflict #(.N_CORES(N_CORES)) u_cf (
        .eff(dir_eff), .req_child(in_req_child), .want(msi_t'(in_req_state)),
        .pend(pend_q), .any_conflict(any_conflict), .issue_any(issue_any),
        .issue_idx(issue_idx), .target(dg_target)
    );

    assign grant_fire  = (st_q == C_SEND) && out_valid && out_ready && out_is_resp;
    assign dg_fire     = (st_q == C_SEND) && out_valid && out_ready && !out_is_resp;
    assign in_resp_deq = (st_q == C_IDLE) && in_resp_valid;
    assign in_req_deq  = grant_fire;
    assign rd_addr     = (st_q == C_IDLE) ? in_req_addr : cur_addr;

    // Directory write select: response updates (tag-checked) or grant updates.
    always_comb begin
        wr_en       = 1'b0;
        wr_need_hit = 1'b0;
        wr_core     = cur_child;
        wr_addr     = cur_addr;
        wr_state    = cur_state;
        if (in_resp_deq) begin
            wr_en       = 1'b1;
            wr_need_hit = 1'b1;
            wr_core     = in_resp_child;
            wr_addr     = in_resp_addr;
            wr_state    = msi_t'(in_resp_state);
        end else if (grant_fire) begin
            wr_en = 1'b1;
        end
    end

    // Control sequence: response service, permission check, memory access, send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= C_IDLE;
            pend_q        <= '0;
            cur_child     <= '0;
            cur_addr      <= '0;
            cur_state     <= ST_I;
            out_valid     <= 1'b0;
            out_is_resp   <= 1'b0;
            out_child     <= '0;
            out_addr      <= '0;
            out_state     <= 2'b00;
            out_has_data  <= 1'b0;
            out_data      <= '0;
            mem_req_valid <= 1'b0;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
        end else begin
            case (st_q)
                C_IDLE: begin
                    if (in_resp_valid) begin
                        if (in_req_valid && in_resp_addr == in_req_addr)
                            pend_q[in_resp_child] <= 1'b0;
                        if (in_resp_has_data) begin
                            mem_req_valid <= 1'b1;
                            mem_req_we    <= 1'b1;
                            mem_req_addr  <= in_resp_addr;
                            mem_req_wdata <= in_resp_data;
                            st_q          <= C_WB;
                        end
                    end else if (in_req_valid) begin
                        cur_child <= in_req_child;
                        cur_addr  <= in_req_addr;
                        cur_state <= msi_t'(in_req_state);
                        if (!any_conflict) begin
                            if (dir_eff[in_req_child] == ST_I) begin
                                mem_req_valid <= 1'b1;
                                mem_req_we    <= 1'b0;
                                mem_req_addr  <= in_req_addr;
                                st_q          <= C_RD;
                            end else begin
                                out_valid    <= 1'b1;
                                out_is_resp  <= 1'b1;
                                out_child    <= in_req_child;
                                out_addr     <= in_req_addr;
                                out_state    <= in_req_state;
                                out_has_data <= 1'b0;
                                out_data     <= '0;
                                st_q         <= C_SEND;
                            end
                        end else if (issue_any) begin
                            out_valid    <= 1'b1;
                            out_is_resp  <= 1'b0;
                            out_child    <= issue_idx;
                            out_addr     <= in_req_addr;
                            out_state    <= dg_target;
                            out_has_data <= 1'b0;
                            out_data     <= '0;
                            st_q         <= C_SEND;
                        end
                    end
                end
                C_WB: begin
                    if (mem_req_ready) begin
                        mem_req_valid <= 1'b0;
                        st_q          <= C_IDLE;
                    end
                end
                C_RD: begin
                    if (mem_req_ready) begin
                        mem_req_valid <= 1'b0;
                        st_q          <= C_RDW;
                    end
                end
                C_RDW: begin
                    if (mem_resp_valid) begin
                        out_valid    <= 1'b1;
                        out_is_resp  <= 1'b1;
                        out_child    <= cur_child;
                        out_addr     <= cur_addr;
                        out_state    <= cur_state;
                        out_has_data <= 1'b1;
                        out_data     <= mem_resp_data;
                        st_q         <= C_SEND;
                    end
                end
                C_SEND: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        st_q      <= C_IDLE;
                        if (grant_fire) pend_q <= '0;
                        if (dg_fire)    pend_q[out_child] <= 1'b1;
                    end
                end
                default: st_q <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msi_dir_ctrl_chk.sv
// Protocol checker for msi_dir_ctrl, attached by bind. Uses the directory
// lookup the controller performs for the line it is answering.
module msi_dir_ctrl_chk #(
    parameter int N_CORES = 2,
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 32,
    localparam int CID_W  = $clog2(N_CORES > 1 ? N_CORES : 2)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_is_resp,
    input logic [CID_W-1:0]        out_child,
    input logic [ADDR_W-1:0]       out_addr,
    input logic [1:0]              out_state,
    input logic                    out_has_data,
    input logic [LINE_W-1:0]       out_data,
    input logic                    mem_req_valid,
    input logic                    mem_req_ready,
    input logic                    mem_req_we,
    input logic [ADDR_W-1:0]       mem_req_addr,
    input logic [LINE_W-1:0]       mem_req_wdata,
    input logic [N_CORES-1:0][1:0] dir_eff
);
    logic others_non_i, others_m;

    // Summarise the other cores' directory states for the line being answered.
    always_comb begin
        others_non_i = 1'b0;
        others_m     = 1'b0;
        for (int j = 0; j < N_CORES; j++) begin
            if (j != int'(out_child)) begin
                if (dir_eff[j] != 2'b00) others_non_i = 1'b1;
                if (dir_eff[j] == 2'b10) others_m     = 1'b1;
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && !mem_req_valid));

    a_r3_m_grant_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_resp && out_state == 2'b10) |-> !others_non_i);

    a_r4_s_grant_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_resp && out_state == 2'b01) |-> !others_m);

    a_r7_dgreq_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_resp) |-> !out_has_data);

    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid &&
            $stable({out_is_resp, out_child, out_addr, out_state, out_has_data, out_data})));

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid &&
            $stable({mem_req_we, mem_req_addr, mem_req_wdata})));
endmodule

bind msi_dir_ctrl msi_dir_ctrl_chk #(
    .N_CORES(N_CORES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_resp(out_is_resp), .out_child(out_child), .out_addr(out_addr),
    .out_state(out_state), .out_has_data(out_has_data), .out_data(out_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .dir_eff(dir_eff)
);

// File: tb/sim_msi_dir_ctrl.sv
// Bench: acts as four child caches and a simple memory, and keeps a
// behavioural directory model that predicts every outgoing message.
module sim_msi_dir_ctrl;
    localparam int CLK_P = 10;
    localparam int NC = 4, RW = 4, AW = 8, LW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_resp_valid = 0, in_resp_has_data = 0, in_resp_deq;
    logic [1:0] in_resp_child = 0, in_resp_state = 0;
    logic [AW-1:0] in_resp_addr = 0;
    logic [LW-1:0] in_resp_data = 0;
    logic in_req_valid = 0, in_req_deq;
    logic [1:0] in_req_child = 0, in_req_state = 0;
    logic [AW-1:0] in_req_addr = 0;
    logic out_valid, out_ready = 1, out_is_resp, out_has_data;
    logic [1:0] out_child, out_state;
    logic [AW-1:0] out_addr;
    logic [LW-1:0] out_data;
    logic mem_req_valid, mem_req_ready = 1, mem_req_we, mem_resp_valid = 0;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_req_wdata, mem_resp_data = 0;

    always #(CLK_P/2) clk = ~clk;

    msi_dir_ctrl #(.N_CORES(NC), .ROWS(RW), .ADDR_W(AW), .LINE_W(LW)) u0 (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0, dcount = 0;
    bit done = 0;
    logic [63:0] gotq[$];
    logic [63:0] expw[$];
    int due[$];
    logic [LW-1:0] dq[$];
    logic [LW-1:0] bank[int];
    logic [LW-1:0] memx[int];
    int mst[NC][RW];
    int mtag[NC][RW];
    logic [LW-1:0] dirty[NC];
    int last_rd = -1;

    function automatic logic [LW-1:0] memdef(int a);
        return LW'(a) * 32'h0101_0101 ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [LW-1:0] memv(int a);
        return memx.exists(a) ? memx[a] : memdef(a);
    endfunction

    function automatic int eff(int c, int a);
        return (mtag[c][a % RW] == a / RW) ? mst[c][a % RW] : 0;
    endfunction

    function automatic logic [63:0] pk(bit r, int ch, int ad, int s, bit hd, logic [LW-1:0] d);
        return {18'b0, r, ch[1:0], ad[AW-1:0], s[1:0], hd, d};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One clock: record handshakes at the falling edge, update drives after the rising edge.
    task automatic tick();
        bit rtk, qtk;
        @(negedge clk);
        rtk = in_resp_valid && in_resp_deq;
        qtk = in_req_valid && in_req_deq;
        if (out_valid && out_ready)
            gotq.push_back({18'b0, out_is_resp, out_child, out_addr, out_state, out_has_data, out_data});
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                bank[int'(mem_req_addr)] = mem_req_wdata;
                if (expw.size() > 0) chk("R6 write-back", {24'b0, mem_req_addr, mem_req_wdata}, expw.pop_front());
                else chk("R6 unexpected write", 64'd1, 64'd0);
            end else begin
                last_rd = int'(mem_req_addr);
                due.push_back(cyc + 3);
                dq.push_back(bank.exists(last_rd) ? bank[last_rd] : memdef(last_rd));
            end
        end
        @(posedge clk);
        #1;
        if (rtk) in_resp_valid = 0;
        if (qtk) in_req_valid = 0;
        if (due.size() > 0 && due[0] <= cyc) begin
            mem_resp_valid = 1;
            mem_resp_data  = dq.pop_front();
            void'(due.pop_front());
        end else begin
            mem_resp_valid = 0;
        end
        out_ready     = (cyc % 5) != 3;
        mem_req_ready = (cyc % 7) != 2;
        cyc++;
    endtask

    task automatic wait_msg(string tag);
        int t = 0;
        while (gotq.size() == 0 && t < 2000) begin tick(); t++; end
        if (gotq.size() == 0) begin
            chk({tag, " message timeout"}, 64'd1, 64'd0);
            gotq.push_back('1);
        end
    endtask

    // A core reports its drop to state tgt; dirty data goes with it when it held M.
    task automatic do_resp(int j, int a, int tgt, string tag, bit stalled);
        int t = 0;
        bit hd = (eff(j, a) == 2);
        in_resp_child = j[1:0]; in_resp_addr = a[AW-1:0]; in_resp_state = tgt[1:0];
        in_resp_has_data = hd; in_resp_data = hd ? dirty[j] : '0;
        if (hd) begin
            memx[a] = dirty[j];
            expw.push_back({24'b0, a[AW-1:0], dirty[j]});
        end
        in_resp_valid = 1;
        while (in_resp_valid && t < 2000) begin tick(); t++; end
        if (stalled) chk({tag, " R8 resp consumed while stalled"}, {62'b0, t <= 10, in_req_valid}, 64'd3);
        mst[j][a % RW] = tgt;
    endtask

    // A core asks for state s on line a; model predicts downgrades and the grant.
    task automatic do_req(int c, int a, int s, string tag);
        int dg[$];
        int row = a % RW, tgt = (s == 2) ? 0 : 1, t = 0;
        bit hd;
        if (mtag[c][row] != a / RW && mst[c][row] != 0)
            do_resp(c, mtag[c][row] * RW + row, 0, {tag, " evict"}, 0);
        if (eff(c, a) >= s) return;
        for (int j = 0; j < NC; j++)
            if (j != c && ((s == 2) ? eff(j, a) != 0 : eff(j, a) == 2)) dg.push_back(j);
        in_req_child = c[1:0]; in_req_addr = a[AW-1:0]; in_req_state = s[1:0];
        in_req_valid = 1;
        foreach (dg[k]) begin
            wait_msg(tag);
            chk({tag, " R3/R4/R5 downgrade request"}, gotq.pop_front(), pk(0, dg[k], a, tgt, 0, '0));
        end
        if (dg.size() > 0) begin
            repeat (8) tick();
            chk({tag, " R5 no duplicate, still stalled"}, {63'(gotq.size()), in_req_valid}, 64'd1);
        end
        foreach (dg[k]) do_resp(dg[k], a, tgt, tag, 1);
        wait_msg(tag);
        hd = (eff(c, a) == 0);
        chk({tag, " R7 upgrade response"}, gotq.pop_front(), pk(1, c, a, s, hd, hd ? memv(a) : '0));
        if (hd) chk({tag, " R10 read address"}, 64'(last_rd), 64'(a));
        while (in_req_valid && t < 2000) begin tick(); t++; end
        chk({tag, " R9 request consumed"}, {63'b0, in_req_valid}, 64'd0);
        mst[c][row] = s; mtag[c][row] = a / RW;
        if (s == 2) begin dirty[c] = 32'hD000_0000 + LW'(dcount); dcount++; end
    endtask

    initial begin
        int seed = 7;
        for (int c = 0; c < NC; c++) for (int r = 0; r < RW; r++) begin mst[c][r] = 0; mtag[c][r] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset quiet", {61'b0, out_valid, mem_req_valid, in_resp_deq}, 64'd0);
        do_req(0, 8'h10, 1, "R1 first S");
        do_req(1, 8'h10, 1, "R4 second S");
        do_req(2, 8'h10, 2, "R3 M over two S");
        do_req(3, 8'h10, 1, "R6 S over M");
        do_req(3, 8'h10, 2, "R7 S to M");
        do_req(0, 8'h14, 1, "R2 other tag");
        do_resp(3, 8'h10, 0, "R9 evict", 0);
        do_req(1, 8'h10, 1, "R9 after evict");
        do_req(1, 8'h10, 2, "R7 sole S to M");
        for (int i = 0; i < 40; i++) begin
            int addrs[4] = '{8'h10, 8'h14, 8'h11, 8'h20};
            seed = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
            do_req((seed >> 4) % NC, addrs[(seed >> 8) % 4], 1 + ((seed >> 12) % 2), "R5 mixed");
        end
        repeat (5) tick();
        chk("R10 no stray traffic", {63'(gotq.size()), 1'b0} | 64'(expw.size()), 64'd0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule